// File: doc/BRIEF.md
# Control-Endpoint Status Register with SIE/CPU Arbitration

This block is the control and status register of a USB control endpoint. Two agents may change it: the serial interface engine (SIE), which reports the kind of token it last received and whether the transaction closed with an ACK, and a CPU bus with separate read and write strobes. The register holds three sticky token flags (setup, IN, OUT), an acknowledge flag and a mode field. The bit layout, from the most significant bit down, is: setup flag, IN flag, OUT flag, acknowledge flag, then the mode field in the low `MODE_W` bits.

Arbitration works through a lock. When the SIE finishes a transaction, the register locks the IN, OUT, acknowledge and mode bits against CPU writes. The lock stays set until the CPU reads the register, so firmware must read the register back after each write to see what was stored. The setup flag follows a stricter rule. It is forced high while the data phase of a setup transaction is in progress, and once that phase ends the CPU still cannot clear it until the CPU has read the register.

The same block also gates CPU writes into the endpoint buffer memory. While the setup flag is set, writes that fall inside the two protected address windows are dropped. This prevents an incoming setup packet from colliding with firmware that is still filling an IN buffer.

Top module: `ep0_stat_arb`

## Requirements
- R1: Reset is synchronous and active high. It clears the status register, the lock, the setup force and hold state, `buf_we` and `cpu_rdata`.
- R2: A `cpu_rd` at address `REG_ADDR` presents the status value on `cpu_rdata` in the next cycle, with bit 7 = setup, bit 6 = IN, bit 5 = OUT, bit 4 = ack and bits 3:0 = mode. The same read clears the lock.
- R3: While the register is unlocked, a `cpu_wr` at `REG_ADDR` stores `cpu_wdata` into bits 6:0. Bit 7 is stored as well unless R6 or R7 prevents it.
- R4: A `sie_done` pulse sets one flag chosen by `sie_kind` (0 = setup, 1 = IN, 2 = OUT). It also sets bit 4 when `sie_ack` is 1, loads the mode field from `sie_mode` when `sie_mode_ld` is 1, leaves every other bit unchanged, and sets the lock.
- R5: While the lock is set, CPU writes leave bits 6:0 unchanged. This lasts until a CPU read of the register.
- R6: From a `sie_setup_data` pulse until a `sie_ack_start` pulse, bit 7 reads 1 and no CPU write can clear it.
- R7: After the forced interval, bit 7 still cannot be cleared by a CPU write until a CPU read of the register has occurred outside the forced interval.
- R8: If `sie_done` and a CPU write to the register occur in the same cycle, the write is discarded and the lock is set. If `sie_done` coincides with a CPU read, the lock is still set.
- R9: A `cpu_wr` to any address other than `REG_ADDR` produces `buf_we` = 1 in the next cycle, with the address and data registered alongside it. The exception is when bit 7 is set and the address lies in 0xE0–0xE7 or 0xF8–0xFF; then `buf_we` stays 0.
- R10: Bits 7:4 never go from 1 to 0 except through a CPU write to the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sie_setup_data | input | 1 | Pulse: data phase of a setup transaction begins |
| sie_ack_start | input | 1 | Pulse: the SIE begins sending the ACK handshake |
| sie_done | input | 1 | Pulse: SIE transaction complete, register update |
| sie_kind | input | 2 | Token kind for the update: 0 setup, 1 IN, 2 OUT |
| sie_ack | input | 1 | Transaction ended with ACK |
| sie_mode_ld | input | 1 | Load the mode field on this update |
| sie_mode | input | MODE_W | New mode value |
| cpu_addr | input | ADDR_W | CPU bus address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rdata | output | DATA_W | Registered read data of the status register |
| buf_we | output | 1 | Gated buffer write enable |
| buf_waddr | output | ADDR_W | Buffer write address aligned with buf_we |
| buf_wdata | output | DATA_W | Buffer write data aligned with buf_we |

## Verification
The hardest state to reach is the one where the setup flag is held after the forced interval has ended but before any read has released it. Here the mode and token bits are still writable, yet bit 7 is not. The stimulus pulses the data-phase and ACK-start events, issues one read while the force is still active (that read must not release the hold), and then writes zero. It then reads back only after the SIE completion, so one readback shows bit 7 kept through both the hold and the lock. The two same-cycle collisions (completion with a write, and completion with a read) are driven on a single edge, and their effect is judged from the write that follows.

// File: rtl/ep0_stat_pkg.sv
package ep0_stat_pkg;

  typedef enum logic [1:0] {
    TOK_SETUP = 2'd0,
    TOK_IN    = 2'd1,
    TOK_OUT   = 2'd2,
    TOK_NONE  = 2'd3
  } tok_kind_e;

  // Positions of the flag bits above the mode field
  localparam int FLG_ACK   = 0;
  localparam int FLG_OUT   = 1;
  localparam int FLG_IN    = 2;
  localparam int FLG_SETUP = 3;
  localparam int NUM_FLG   = 4;

endpackage

// File: rtl/ep0_setup_guard.sv
// Tracks the forced interval of the setup flag and the hold that follows it.
module ep0_setup_guard (
  input  logic clk,
  input  logic rst,
  input  logic data_start,
  input  logic ack_start,
  input  logic rd_hit,
  output logic force_q,
  output logic hold_q,
  output logic clr_ok
);

  logic force_d;
  logic hold_d;

  always_comb begin
    force_d = force_q;
    if (ack_start)  force_d = 1'b0;
    if (data_start) force_d = 1'b1;
  end

  always_comb begin
    hold_d = hold_q;
    if (rd_hit && !force_q) hold_d = 1'b0;
    if (data_start)         hold_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      force_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      force_q <= force_d;
      hold_q  <= hold_d;
    end
  end

  assign clr_ok = !force_q && !hold_q;

endmodule

// File: rtl/ep0_lock.sv
// Lock set by an SIE update, released by a CPU read; the update wins a tie.
module ep0_lock (
  input  logic clk,
  input  logic rst,
  input  logic sie_upd,
  input  logic rd_hit,
  output logic lock_q
);

  logic lock_d;

  always_comb begin
    lock_d = lock_q;
    if (rd_hit)  lock_d = 1'b0;
    if (sie_upd) lock_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) lock_q <= 1'b0;
    else     lock_q <= lock_d;
  end

endmodule

// File: rtl/ep0_buf_gate.sv
// Registered buffer write port with suppression inside protected windows.
module ep0_buf_gate #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int NUM_WIN  = 2,
  parameter int WIN_SPAN = 8,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_BASES = {8'hF8, 8'hE0},
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              guard_on,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_wr,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_waddr,
  output logic [DATA_W-1:0] buf_wdata
);

  localparam int SPAN_W = $clog2(WIN_SPAN);

  logic [NUM_WIN-1:0] win_hit;
  logic               in_window;
  logic               we_d;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE = WIN_BASES[g*ADDR_W +: ADDR_W];
    assign win_hit[g] = (cpu_addr[ADDR_W-1:SPAN_W] == BASE[ADDR_W-1:SPAN_W]);
  end

  assign in_window = |win_hit;
  assign we_d = cpu_wr && (cpu_addr != REG_ADDR) && !(guard_on && in_window);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_we    <= 1'b0;
      buf_waddr <= '0;
      buf_wdata <= '0;
    end else begin
      buf_we <= we_d;
      if (cpu_wr) begin
        buf_waddr <= cpu_addr;
        buf_wdata <= cpu_wdata;
      end
    end
  end

endmodule

// File: rtl/ep0_stat_arb.sv
module ep0_stat_arb #(
  parameter int MODE_W   = 4,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10,
  parameter int NUM_WIN  = 2,
  parameter int WIN_SPAN = 8,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_BASES = {8'hF8, 8'hE0},
  localparam int DATA_W  = MODE_W + ep0_stat_pkg::NUM_FLG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sie_setup_data,
  input  logic              sie_ack_start,
  input  logic              sie_done,
  input  logic [1:0]        sie_kind,
  input  logic              sie_ack,
  input  logic              sie_mode_ld,
  input  logic [MODE_W-1:0] sie_mode,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_waddr,
  output logic [DATA_W-1:0] buf_wdata
);
  import ep0_stat_pkg::*;

  localparam int B_ACK   = MODE_W + FLG_ACK;
  localparam int B_OUT   = MODE_W + FLG_OUT;
  localparam int B_IN    = MODE_W + FLG_IN;
  localparam int B_SETUP = MODE_W + FLG_SETUP;

  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] status_d;
  logic              rd_hit;
  logic              wr_hit;
  logic              lock_q;
  logic              force_q;
  logic              hold_q;
  logic              clr_ok;
  tok_kind_e         kind;

  assign rd_hit = cpu_rd && (cpu_addr == REG_ADDR);
  assign wr_hit = cpu_wr && (cpu_addr == REG_ADDR);
  assign kind   = tok_kind_e'(sie_kind);

  ep0_setup_guard u_guard (
    .clk        (clk),
    .rst        (rst),
    .data_start (sie_setup_data),
    .ack_start  (sie_ack_start),
    .rd_hit     (rd_hit),
    .force_q    (force_q),
    .hold_q     (hold_q),
    .clr_ok     (clr_ok)
  );

  ep0_lock u_lock (
    .clk     (clk),
    .rst     (rst),
    .sie_upd (sie_done),
    .rd_hit  (rd_hit),
    .lock_q  (lock_q)
  );

  ep0_buf_gate #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_WIN  (NUM_WIN),
    .WIN_SPAN (WIN_SPAN),
    .WIN_BASES(WIN_BASES),
    .REG_ADDR (REG_ADDR)
  ) u_gate (
    .clk       (clk),
    .rst       (rst),
    .guard_on  (status_q[B_SETUP]),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_wr    (cpu_wr),
    .buf_we    (buf_we),
    .buf_waddr (buf_waddr),
    .buf_wdata (buf_wdata)
  );

  // Next status: CPU write first, SIE update overrides, forced setup last.
  always_comb begin
    status_d = status_q;
    if (wr_hit && !sie_done) begin
      if (!lock_q) status_d[B_SETUP-1:0] = cpu_wdata[B_SETUP-1:0];
      if (cpu_wdata[B_SETUP] || clr_ok) status_d[B_SETUP] = cpu_wdata[B_SETUP];
    end
    if (sie_done) begin
      unique case (kind)
        TOK_SETUP: status_d[B_SETUP] = 1'b1;
        TOK_IN:    status_d[B_IN]    = 1'b1;
        TOK_OUT:   status_d[B_OUT]   = 1'b1;
        default:   ;
      endcase
      if (sie_ack)     status_d[B_ACK] = 1'b1;
      if (sie_mode_ld) status_d[MODE_W-1:0] = sie_mode;
    end
    if (sie_setup_data) status_d[B_SETUP] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= '0;
      cpu_rdata <= '0;
    end else begin
      status_q <= status_d;
      if (rd_hit) cpu_rdata <= status_q;
    end
  end

endmodule

// File: rtl/ep0_stat_arb_chk.sv
module ep0_stat_arb_chk #(
  parameter int MODE_W = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10
) (
  input logic              clk,
  input logic              rst,
  input logic              sie_done,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic              buf_we,
  input logic [DATA_W-1:0] status_q,
  input logic              lock_q,
  input logic              force_q
);

  logic wr_hit;
  logic rd_hit;
  logic prot;

  assign wr_hit = cpu_wr && (cpu_addr == REG_ADDR);
  assign rd_hit = cpu_rd && (cpu_addr == REG_ADDR);
  assign prot   = (cpu_addr[ADDR_W-1:3] == 5'b11100) || (cpu_addr[ADDR_W-1:3] == 5'b11111);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (status_q == '0) && !lock_q && !buf_we);

  a_r2_read_unlocks: assert property (@(posedge clk) disable iff (rst)
    rd_hit && !sie_done |=> !lock_q);

  a_r4_done_locks: assert property (@(posedge clk) disable iff (rst)
    sie_done |=> lock_q);

  a_r5_locked_keep: assert property (@(posedge clk) disable iff (rst)
    lock_q && wr_hit && !sie_done |=> status_q[DATA_W-2:0] == $past(status_q[DATA_W-2:0]));

  a_r6_forced_setup: assert property (@(posedge clk) disable iff (rst)
    force_q |-> status_q[DATA_W-1]);

  a_r8_done_beats_write: assert property (@(posedge clk) disable iff (rst)
    sie_done && wr_hit |=> ($past(status_q) & ~status_q) == '0);

  a_r9_window_block: assert property (@(posedge clk) disable iff (rst)
    cpu_wr && prot && status_q[DATA_W-1] |=> !buf_we);

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> ($past(status_q[DATA_W-1:MODE_W]) & ~status_q[DATA_W-1:MODE_W]) == '0);

endmodule

bind ep0_stat_arb ep0_stat_arb_chk #(
  .MODE_W  (MODE_W),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .REG_ADDR(REG_ADDR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sie_done (sie_done),
  .cpu_addr (cpu_addr),
  .cpu_wr   (cpu_wr),
  .cpu_rd   (cpu_rd),
  .buf_we   (buf_we),
  .status_q (status_q),
  .lock_q   (lock_q),
  .force_q  (force_q)
);

// File: tb/ep0_stat_arb_bench.sv
`timescale 1ns/1ps
module ep0_stat_arb_bench;

  localparam logic [7:0] RADDR = 8'h10;
  // op: 0 write reg, 1 read+check, 2 SIE done, 3 setup data start, 4 ack start
  localparam int NV = 22;
  // {op[2:0], kind[1:0], ack, mode_ld, data[7:0], expect[7:0]}
  localparam logic [22:0] VEC [NV] = '{
    {3'd0, 2'd0, 1'b0, 1'b0, 8'h05, 8'h00},
    {3'd1, 2'd0, 1'b0, 1'b0, 8'h00, 8'h05},
    {3'd2, 2'd1, 1'b1, 1'b0, 8'h00, 8'h00},
    {3'd0, 2'd0, 1'b0, 1'b0, 8'h03, 8'h00},
    {3'd1, 2'd0, 1'b0, 1'b0, 8'h00, 8'h55},
    {3'd0, 2'd0, 1'b0, 1'b0, 8'h03, 8'h00},
    {3'd1, 2'd0, 1'b0, 1'b0, 8'h00, 8'h03},
    {3'd3, 2'd0, 1'b0, 1'b0, 8'h00, 8'h00},
    {3'd0, 2'd0, 1'b0, 1'b0, 8'h00, 8'h00},
    {3'd1, 2'd0, 1'b0, 1'b0, 8'h00, 8'h80},
    {3'd4, 2'd0, 1'b0, 1'b0, 8'h00, 8'h00},
    {3'd0, 2'd0, 1'b0, 1'b0, 8'h00, 8'h00},
    {3'd2, 2'd0, 1'b1, 1'b0, 8'h00, 8'h00},
    {3'd0, 2'd0, 1'b0, 1'b0, 8'h00, 8'h00},
    {3'd1, 2'd0, 1'b0, 1'b0, 8'h00, 8'h90},
    {3'd0, 2'd0, 1'b0, 1'b0, 8'h00, 8'h00},
    {3'd1, 2'd0, 1'b0, 1'b0, 8'h00, 8'h00},
    {3'd2, 2'd2, 1'b0, 1'b0, 8'h00, 8'h00},
    {3'd1, 2'd0, 1'b0, 1'b0, 8'h00, 8'h20},
    {3'd2, 2'd1, 1'b1, 1'b1, 8'h0A, 8'h00},
    {3'd1, 2'd0, 1'b0, 1'b0, 8'h00, 8'h7A},
    {3'd0, 2'd0, 1'b0, 1'b0, 8'h00, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sie_setup_data = 0, sie_ack_start = 0, sie_done = 0;
  logic [1:0] sie_kind = 0;
  logic       sie_ack = 0, sie_mode_ld = 0;
  logic [3:0] sie_mode = 0;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0;
  logic       cpu_wr = 0, cpu_rd = 0;
  logic [7:0] cpu_rdata;
  logic       buf_we;
  logic [7:0] buf_waddr, buf_wdata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ep0_stat_arb u_ep0_stat_arb (
    .clk(clk), .rst(rst),
    .sie_setup_data(sie_setup_data), .sie_ack_start(sie_ack_start),
    .sie_done(sie_done), .sie_kind(sie_kind), .sie_ack(sie_ack),
    .sie_mode_ld(sie_mode_ld), .sie_mode(sie_mode),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_rdata(cpu_rdata), .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Inputs are set at a falling edge, one rising edge passes, and the
  // bench returns at the next falling edge with all strobes low.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    sie_setup_data = 0; sie_ack_start = 0; sie_done = 0;
    sie_ack = 0; sie_mode_ld = 0; cpu_wr = 0; cpu_rd = 0;
  endtask

  task automatic reg_wr(input logic [7:0] d);
    cpu_addr = RADDR; cpu_wdata = d; cpu_wr = 1; tick();
  endtask

  task automatic reg_rd(input string req, input logic [7:0] exp);
    cpu_addr = RADDR; cpu_rd = 1; tick();
    check(req, cpu_rdata, exp);
  endtask

  task automatic done(input logic [1:0] k, input logic a, input logic ld, input logic [3:0] m);
    sie_done = 1; sie_kind = k; sie_ack = a; sie_mode_ld = ld; sie_mode = m;
  endtask

  function automatic string vec_req(input int i);
    case (i)
      1, 6:  return "R3";
      4:     return "R5";
      9:     return "R6";
      14:    return "R7";
      16:    return "R7";
      18:    return "R4";
      20:    return "R10";
      default: return "R2";
    endcase
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1", {7'd0, buf_we}, 8'h00);
    check("R1", cpu_rdata, 8'h00);
    reg_rd("R1", 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      case (v[22:20])
        3'd0: reg_wr(v[15:8]);
        3'd1: reg_rd(vec_req(i), v[7:0]);
        3'd2: begin done(v[19:18], v[17], v[16], v[11:8]); tick(); end
        3'd3: begin sie_setup_data = 1; tick(); end
        default: begin sie_ack_start = 1; tick(); end
      endcase
    end
    reg_rd("R3", 8'h00);

    // R8: completion and write in the same cycle
    done(2'd2, 1'b0, 1'b0, 4'h0);
    cpu_addr = RADDR; cpu_wdata = 8'h0F; cpu_wr = 1; tick();
    reg_wr(8'h0F);
    reg_rd("R8", 8'h20);
    // R8: completion and read in the same cycle keeps the lock
    done(2'd1, 1'b0, 1'b0, 4'h0);
    cpu_addr = RADDR; cpu_rd = 1; tick();
    check("R8", cpu_rdata, 8'h20);
    reg_wr(8'h00);
    reg_rd("R8", 8'h60);
    reg_wr(8'h00);
    reg_rd("R2", 8'h00);

    // R9: sweep buffer addresses with setup set
    sie_setup_data = 1; tick();
    for (int a = 8'hD0; a <= 8'hFF; a++) begin
      logic exp_we;
      exp_we = !((a >= 8'hE0 && a <= 8'hE7) || (a >= 8'hF8));
      cpu_addr = 8'(a); cpu_wdata = 8'(a ^ 8'h5A); cpu_wr = 1; tick();
      check("R9", {7'd0, buf_we}, {7'd0, exp_we});
      if (exp_we) check("R9", buf_waddr, 8'(a));
    end
    // release: end force, read, clear setup; protected address now passes
    sie_ack_start = 1; tick();
    reg_rd("R7", 8'h80);
    reg_wr(8'h00);
    reg_rd("R7", 8'h00);
    cpu_addr = 8'hE3; cpu_wdata = 8'hC4; cpu_wr = 1; tick();
    check("R9", {7'd0, buf_we}, 8'h01);
    check("R9", buf_wdata, 8'hC4);
    cpu_addr = RADDR; cpu_wdata = 8'h00; cpu_wr = 1; tick();
    check("R9", {7'd0, buf_we}, 8'h00);

    // R1: reset in mid-operation clears everything
    done(2'd1, 1'b1, 1'b1, 4'h7); tick();
    rst = 1; tick(); rst = 0;
    reg_wr(8'h03);
    reg_rd("R1", 8'h03);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule